// File: doc/BRIEF.md
# Parallel Frame Whitening Scrambler

This block whitens transmit data one 24-bit frame per clock. A 7-bit linear feedback shift register defines a pseudo-random bit sequence that repeats every 127 bits. For each accepted frame the block computes the next 24 sequence bits combinationally from the current register value, XORs them onto the frame, and moves the register 24 steps forward in the same cycle. The sequence is never stored. Every frame's key bits are derived on the fly from the state alone.

A message begins with a one-cycle start strobe that carries a seed. The seed is written into the shift register in that single cycle, and the frames that follow are scrambled from it. Input and output use valid/ready handshakes. The output register holds its frame while the downstream side stalls. During a stall no new frame is taken and the sequence does not move.

Top module: `frame_whitener`

## Requirements
- R1: Let state bits be s[6:0]. One sequence step computes f = s[6] XOR s[3], emits f, and shifts the state to {s[5:0], f}. For an accepted frame, out_data bit i equals in_data bit i XOR the i-th bit emitted from the current state, counting from bit 0.
- R2: While out_ready stays high and no start strobe is present, a frame can be accepted on every clock. Each accepted frame appears on out_data with out_valid high one clock after acceptance.
- R3: Each accepted frame moves the state exactly 24 steps forward. The next frame therefore continues the sequence where the previous frame stopped.
- R4: When msg_start is high, in_ready is low in that cycle and msg_seed is written into the state in one clock. The next accepted frame is scrambled starting from that seed.
- R5: A msg_seed of zero is written as all ones (7'h7F).
- R6: While out_valid is high and out_ready is low, out_valid and out_data hold, in_ready is low, and the state does not advance.
- R7: After reset, out_valid is low and the state is all ones. With no start strobe, the first frame is scrambled from 7'h7F.
- R8: The state never becomes zero. With all-zero input, frame k and frame k+127 of a continuous run produce equal outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Message start strobe; writes the seed |
| msg_seed | input | 7 | Seed for the new message |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Block can take a frame this cycle |
| in_data | input | 24 | Input frame |
| out_valid | output | 1 | Scrambled frame present |
| out_ready | input | 1 | Downstream side takes the frame |
| out_data | output | 24 | Scrambled frame |

## Verification
All-zero frames expose the raw key stream. They show whether bit order, tap positions and the 24-step advance are correct, and a 254-frame zero run confirms the 127-bit period. Random frames, mixed with random gaps, stalls and occasional reseeds (some of them zero), test whether the XOR lands on the matching bit and whether the state holds correctly across idle and stalled cycles. Directed cases cover a first frame straight after reset, a zero seed, and a long stall with the input held.

// File: rtl/whiten_pkg.sv
package whiten_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_SEED = 2'd1,
      OP_ADV  = 2'd2
   } state_op_e;
endpackage

// File: rtl/whiten_seed_fix.sv
module whiten_seed_fix #(
   parameter int W = 7
) (
   input  logic [W-1:0] seed_i,
   output logic [W-1:0] seed_o
);
   // an all-zero register would lock the sequence at zero
   assign seed_o = (seed_i == '0) ? {W{1'b1}} : seed_i;
endmodule

// File: rtl/whiten_keystream.sv
module whiten_keystream #(
   parameter int FRAME_W = 24,
   parameter int LFSR_W  = 7,
   parameter int TAP_HI  = 6,
   parameter int TAP_LO  = 3
) (
   input  logic [LFSR_W-1:0]  state_i,
   input  logic [FRAME_W-1:0] data_i,
   output logic [FRAME_W-1:0] data_o,
   output logic [LFSR_W-1:0]  next_o
);
   logic [FRAME_W-1:0] key;
   logic [LFSR_W-1:0]  walk;
   logic               fb;

   // unrolled: FRAME_W register steps in one cycle
   always_comb begin
      walk = state_i;
      fb   = 1'b0;
      key  = '0;
      for (int i = 0; i < FRAME_W; i++) begin
         fb     = walk[TAP_HI] ^ walk[TAP_LO];
         key[i] = fb;
         walk   = {walk[LFSR_W-2:0], fb};
      end
      next_o = walk;
   end

   for (genvar g = 0; g < FRAME_W; g++) begin : gen_mix
      assign data_o[g] = data_i[g] ^ key[g];
   end
endmodule

// File: rtl/whiten_out_stage.sv
module whiten_out_stage #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take_i,
   input  logic [W-1:0] data_i,
   input  logic         ready_i,
   output logic         valid_o,
   output logic [W-1:0] data_o,
   output logic         room_o
);
   assign room_o = !valid_o || ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (room_o) begin
         valid_o <= take_i;
         if (take_i) data_o <= data_i;
      end
   end

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/frame_whitener.sv
module frame_whitener
   import whiten_pkg::*;
#(
   parameter int FRAME_W = 24,
   parameter int LFSR_W  = 7,
   parameter int TAP_HI  = 6,
   parameter int TAP_LO  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_start,
   input  logic [LFSR_W-1:0]  msg_seed,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [FRAME_W-1:0] in_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [FRAME_W-1:0] out_data
);
   localparam logic [LFSR_W-1:0] ALL_ONES = {LFSR_W{1'b1}};

   if (FRAME_W < 1) begin : gen_bad_frame
      $error("frame_whitener: FRAME_W must be at least 1");
   end
   if (LFSR_W < 2) begin : gen_bad_lfsr
      $error("frame_whitener: LFSR_W must be at least 2");
   end
   if (TAP_HI >= LFSR_W || TAP_LO >= TAP_HI || TAP_LO < 0) begin : gen_bad_taps
      $error("frame_whitener: taps must satisfy 0 <= TAP_LO < TAP_HI < LFSR_W");
   end

   logic [LFSR_W-1:0]  state_q, seed_fixed, state_adv;
   logic [FRAME_W-1:0] mixed;
   logic               room, accept;
   state_op_e          op;

   whiten_seed_fix #(.W(LFSR_W)) u_seed (
      .seed_i (msg_seed),
      .seed_o (seed_fixed)
   );

   whiten_keystream #(
      .FRAME_W (FRAME_W),
      .LFSR_W  (LFSR_W),
      .TAP_HI  (TAP_HI),
      .TAP_LO  (TAP_LO)
   ) u_ks (
      .state_i (state_q),
      .data_i  (in_data),
      .data_o  (mixed),
      .next_o  (state_adv)
   );

   assign in_ready = room && !msg_start;
   assign accept   = in_valid && in_ready;

   always_comb begin
      if (msg_start)   op = OP_SEED;
      else if (accept) op = OP_ADV;
      else             op = OP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ALL_ONES;
      else begin
         case (op)
            OP_SEED: state_q <= seed_fixed;
            OP_ADV:  state_q <= state_adv;
            default: state_q <= state_q;
         endcase
      end
   end

   whiten_out_stage #(.W(FRAME_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (accept),
      .data_i  (mixed),
      .ready_i (out_ready),
      .valid_o (out_valid),
      .data_o  (out_data),
      .room_o  (room)
   );

   assert_start_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_start |-> !in_ready);
   assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_start && msg_seed != '0) |=> (state_q == $past(msg_seed)));
   assert_zero_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_start && msg_seed == '0) |=> (state_q == ALL_ONES));
   assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_start && !(in_valid && in_ready)) |=> $stable(state_q));
   assert_accept_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
   assert_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
endmodule

// File: tb/sim_frame_whitener.sv
module sim_frame_whitener;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        msg_start;
   logic [6:0]  msg_seed;
   logic        in_valid;
   logic        in_ready;
   logic [23:0] in_data;
   logic        out_valid;
   logic        out_ready;
   logic [23:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [6:0]  m_st;
   logic        m_ov;
   logic [23:0] m_od;
   bit          rec_on = 0;
   int          rec_n = 0;
   logic [23:0] rec [0:259];

   always #4 clk = ~clk;

   frame_whitener u0 (
      .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_seed(msg_seed),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   function automatic void gen(input logic [6:0] s, output logic [23:0] ks,
                               output logic [6:0] ns);
      logic [6:0] r = s;
      ks = '0;
      for (int i = 0; i < 24; i++) begin
         ks[i] = r[6] ^ r[3];
         r = {r[5:0], ks[i]};
      end
      ns = r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic st, input logic [6:0] sd, input logic iv,
                       input logic [23:0] d, input logic ordy, input string tag);
      logic room, erdy, acc;
      logic [23:0] ks;
      logic [6:0] ns;
      @(negedge clk);
      msg_start = st; msg_seed = sd; in_valid = iv; in_data = d; out_ready = ordy;
      #1;
      room = !m_ov || ordy;
      erdy = room && !st;
      acc  = iv && erdy;
      check(in_ready == erdy, {tag, " in_ready"}, 32'(in_ready), 32'(erdy));
      if (st) m_st = (sd == 7'd0) ? 7'h7F : sd;
      else if (acc) begin
         gen(m_st, ks, ns);
         if (room) m_od = d ^ ks;
         m_st = ns;
      end
      if (room) m_ov = acc;
      @(posedge clk);
      #1;
      check(out_valid == m_ov, {tag, " out_valid"}, 32'(out_valid), 32'(m_ov));
      if (m_ov) check(out_data == m_od, {tag, " out_data"}, 32'(out_data), 32'(m_od));
      if (rec_on && acc && rec_n < 260) begin
         rec[rec_n] = out_data;
         rec_n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [23:0] ks;
      logic [6:0]  ns;
      logic [23:0] held;
      void'($urandom(32'd7));
      rst_n = 1'b0; msg_start = 0; msg_seed = 0; in_valid = 0; in_data = 0; out_ready = 1;
      m_st = 7'h7F; m_ov = 0; m_od = '0;
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R7 reset out_valid", 32'(out_valid), 0);
      @(negedge clk) rst_n = 1'b1;

      // R7: first frame with no seed uses all ones; zeros show the raw key
      gen(7'h7F, ks, ns);
      step(0, 0, 1, 24'h0, 1, "R7 R1 first frame");
      check(out_data == ks, "R7 key from ones", 32'(out_data), 32'(ks));
      step(0, 0, 1, 24'h0, 1, "R3 continued frame");

      // R4: seeded message, back-to-back frames (R2)
      step(1, 7'h5D, 1, 24'hABCDEF, 1, "R4 start cycle");
      for (int i = 0; i < 8; i++)
         step(0, 0, 1, 24'($urandom), 1, "R2 R1 R3 back-to-back");

      // random traffic with stalls, gaps and reseeds
      for (int i = 0; i < 600; i++) begin
         logic st = ($urandom % 40) == 0;
         logic [6:0] sd = (($urandom % 3) == 0) ? 7'd0 : 7'($urandom);
         step(st, sd, 1'($urandom % 4 != 0), 24'($urandom),
              1'($urandom % 3 != 0), "R1 R3 R4 R5 R6 random");
      end

      // R5: zero seed behaves as all ones
      step(0, 0, 0, 0, 1, "R5 drain");
      step(1, 7'd0, 0, 0, 1, "R5 zero seed");
      gen(7'h7F, ks, ns);
      step(0, 0, 1, 24'h0, 1, "R5 frame");
      check(out_data == ks, "R5 key from ones", 32'(out_data), 32'(ks));

      // R6: long stall with input held
      step(0, 0, 1, 24'h123456, 0, "R6 fill");
      held = out_data;
      for (int i = 0; i < 4; i++) begin
         step(0, 0, 1, 24'h654321, 0, "R6 stalled");
         check(out_data == held, "R6 data held", 32'(out_data), 32'(held));
      end
      step(0, 0, 1, 24'h654321, 1, "R6 release");
      step(0, 0, 0, 24'h0, 1, "R6 after release");

      // R8: period of 127 on all-zero input
      step(1, 7'h11, 0, 0, 1, "R8 seed");
      rec_on = 1;
      for (int i = 0; i < 254; i++) step(0, 0, 1, 24'h0, 1, "R8 run");
      rec_on = 0;
      for (int k = 0; k < 127; k += 21)
         check(rec[k] == rec[k + 127], "R8 period", 32'(rec[k + 127]), 32'(rec[k]));
      for (int k = 0; k < 126; k++)
         if (rec[k] == 24'h0) check(0, "R8 zero key", 32'(rec[k]), 32'h1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule